// File: doc/BRIEF.md
# Pseudo-Lock Multi-Cycle Transfer Controller

This block breaks a wide memory operand into a run of 32-bit bus cycles and keeps the bus from changing owner partway through the run. While it holds the bus, it drives an active-low pseudo-lock output. On every bus cycle it drives an active-low last-cycle indicator. It also decides when an external hold request may be granted. Operands of 64 bits take two cycles and 128-bit line transfers take four. Each cycle has one address clock, followed by one or more data clocks that end on a ready strobe.

Most locked transfers refuse a hold request until their final cycle completes. A non-cacheable, non-burst code prefetch is the exception: it yields the bus at any cycle boundary and resumes afterwards. A floating-point 64-bit write asserts both the lock and the last-cycle indicator in its first cycle. A request for a locked transfer whose operand is misaligned, or which spans a line boundary, is refused with an error pulse and starts no cycle.

Top module: `plock_xfer_ctrl`

## Requirements
- R1: While reset is low and in the clock after it, lock_n and last_n are 1, hlda and cyc_start are 0, lock_oe is 1 and cyc_num is 0.
- R2: req_kind encodes the transfer: 0 plain single access (1 cycle, unlocked), 1 descriptor read (2 cycles), 2 line fill (4 cycles), 3 floating-point long read (2 cycles), 4 floating-point long write (2 cycles), 5 non-cacheable non-burst code prefetch (4 cycles). Kinds 1 to 5 are locked. Codes 6 and 7 are refused with req_err.
- R3: A locked transfer drives lock_n low from the address clock of its first cycle through the clock before the address clock of its final cycle. lock_n is high in every clock of the final cycle.
- R4: last_n is low in every clock of the final cycle and high otherwise. For every kind except the floating-point write, last_n equals the inverse of lock_n during a bus cycle.
- R5: In the first cycle of a floating-point long write, lock_n and last_n are both low.
- R6: A hold request raised during a locked transfer of kind 1 to 4 is not granted until the final cycle completes. hlda then rises in the clock right after the final ready.
- R7: During a code prefetch, a hold request present at a cycle-ending ready is granted in the next clock. While granted, lock_oe is 0 and no cycle starts. The next cycle's address clock comes in the same clock that hlda falls, and lock_n is low again for it.
- R8: With no transfer in progress, hold raises hlda one clock later. A request is not accepted while hold is high or hlda is high.
- R9: A locked 64-bit request needs req_off to be a multiple of 8 and to lie within the 16-byte line. A 128-bit request needs req_off equal to 0. A failing request pulses req_err in the same clock instead of req_accept, and no cycle starts. A plain single access is not checked.
- R10: rdy is ignored when the bus is idle and in the address clock of a cycle; every cycle lasts at least two clocks.
- R11: An accepted request starts cycle 0 in the next clock. cyc_num counts the cycles of the transfer from 0 upwards, one per address clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_kind | input | 3 | Transfer kind code (see R2) |
| req_off | input | 4 | Byte offset of the operand within its line |
| rdy | input | 1 | Ready: ends the current bus cycle |
| hold | input | 1 | Bus hold request from another master |
| req_accept | output | 1 | Request taken this clock |
| req_err | output | 1 | Request refused this clock (alignment or code) |
| cyc_start | output | 1 | Address clock of a bus cycle |
| cyc_num | output | 2 | Index of the current cycle within the transfer |
| lock_n | output | 1 | Pseudo-lock, active low |
| lock_oe | output | 1 | Output enable for lock_n; 0 while the bus is held |
| last_n | output | 1 | Final cycle of the transfer, active low |
| hlda | output | 1 | Hold acknowledge |

## Verification
Each transfer kind is run with zero and with several wait clocks per cycle. This separates the per-cycle lock and last-cycle pattern from the cycle-length handling. The floating-point write is run next to the floating-point read, which has the same length, so only the first-cycle overlap differs between them. Hold is raised partway through a line fill and partway through a code prefetch. The fill must hold off the grant until the end, while the prefetch must suspend at the boundary and resume at cycle 1. Misaligned, line-crossing and unknown-code requests are set against aligned ones and against an unchecked single access with an odd offset.

// File: rtl/plock_pkg.sv
package plock_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_HELD = 2'd3
    } phase_e;

    localparam logic [2:0] KIND_SINGLE = 3'd0;
    localparam logic [2:0] KIND_DESC   = 3'd1;
    localparam logic [2:0] KIND_FILL   = 3'd2;
    localparam logic [2:0] KIND_FPRD   = 3'd3;
    localparam logic [2:0] KIND_FPWR   = 3'd4;
    localparam logic [2:0] KIND_PREF   = 3'd5;

    localparam int WIDE_BYTES = 8;

endpackage

// File: rtl/plock_req_decode.sv
module plock_req_decode
    import plock_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int BEAT_BYTES = 4,
    parameter int CNT_W      = 2,
    parameter int OFF_W      = 4
) (
    input  logic [2:0]       kind,
    input  logic [OFF_W-1:0] off,
    output logic [CNT_W-1:0] last_idx,
    output logic             locked,
    output logic             yields,
    output logic             fp_write,
    output logic             bad
);
    localparam int WIDE_BEATS = WIDE_BYTES / BEAT_BYTES;
    localparam int LINE_BEATS = LINE_BYTES / BEAT_BYTES;

    logic wide_bad;
    logic line_bad;

    // 64-bit operand: 8-byte aligned and wholly inside one line
    always_comb begin
        wide_bad = ((int'(off) % WIDE_BYTES) != 0) || ((int'(off) + WIDE_BYTES) > LINE_BYTES);
        line_bad = (off != '0);
    end

    always_comb begin
        last_idx = '0;
        locked   = 1'b0;
        yields   = 1'b0;
        fp_write = 1'b0;
        bad      = 1'b0;
        unique case (kind)
            KIND_SINGLE: ;
            KIND_DESC, KIND_FPRD: begin
                last_idx = CNT_W'(WIDE_BEATS - 1);
                locked   = 1'b1;
                bad      = wide_bad;
            end
            KIND_FPWR: begin
                last_idx = CNT_W'(WIDE_BEATS - 1);
                locked   = 1'b1;
                fp_write = 1'b1;
                bad      = wide_bad;
            end
            KIND_FILL: begin
                last_idx = CNT_W'(LINE_BEATS - 1);
                locked   = 1'b1;
                bad      = line_bad;
            end
            KIND_PREF: begin
                last_idx = CNT_W'(LINE_BEATS - 1);
                locked   = 1'b1;
                yields   = 1'b1;
                bad      = line_bad;
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/plock_out_decode.sv
module plock_out_decode
    import plock_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  phase_e           ph,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] last_idx,
    input  logic             locked,
    input  logic             fp_write,
    input  logic             resume,
    output logic             cyc_start,
    output logic             lock_n,
    output logic             lock_oe,
    output logic             last_n,
    output logic             hlda
);
    logic in_cycle;
    logic on_last;
    logic lock_on;

    always_comb begin
        in_cycle  = (ph == PH_ADDR) || (ph == PH_DATA);
        on_last   = (cnt == last_idx);
        // a suspended prefetch still owns the lock logically, but the pin floats
        lock_on   = locked && !on_last && (in_cycle || ((ph == PH_HELD) && resume));
        hlda      = (ph == PH_HELD);
        lock_oe   = !hlda;
        lock_n    = !(lock_on && lock_oe);
        last_n    = !(in_cycle && (on_last || (fp_write && (cnt == '0))));
        cyc_start = (ph == PH_ADDR);
    end
endmodule

// File: rtl/plock_xfer_ctrl.sv
module plock_xfer_ctrl
    import plock_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [2:0]                      req_kind,
    input  logic [$clog2(LINE_BYTES)-1:0]   req_off,
    input  logic                            rdy,
    input  logic                            hold,
    output logic                            req_accept,
    output logic                            req_err,
    output logic                            cyc_start,
    output logic [$clog2(LINE_BYTES/BEAT_BYTES)-1:0] cyc_num,
    output logic                            lock_n,
    output logic                            lock_oe,
    output logic                            last_n,
    output logic                            hlda
);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_BEATS = LINE_BYTES / BEAT_BYTES;
    localparam int CNT_W      = $clog2(LINE_BEATS);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last_idx;
        logic             locked;
        logic             yields;
        logic             fp_write;
        logic             resume;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0] dec_last;
    logic             dec_locked;
    logic             dec_yields;
    logic             dec_fpw;
    logic             dec_bad;

    plock_req_decode #(
        .LINE_BYTES (LINE_BYTES),
        .BEAT_BYTES (BEAT_BYTES),
        .CNT_W      (CNT_W),
        .OFF_W      (OFF_W)
    ) u_dec (
        .kind     (req_kind),
        .off      (req_off),
        .last_idx (dec_last),
        .locked   (dec_locked),
        .yields   (dec_yields),
        .fp_write (dec_fpw),
        .bad      (dec_bad)
    );

    always_comb begin
        ctl_d      = ctl_q;
        req_accept = 1'b0;
        req_err    = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (hold) begin
                    ctl_d.ph     = PH_HELD;
                    ctl_d.resume = 1'b0;
                end else if (req_valid) begin
                    if (dec_bad) begin
                        req_err = 1'b1;
                    end else begin
                        req_accept     = 1'b1;
                        ctl_d.ph       = PH_ADDR;
                        ctl_d.cnt      = '0;
                        ctl_d.last_idx = dec_last;
                        ctl_d.locked   = dec_locked;
                        ctl_d.yields   = dec_yields;
                        ctl_d.fp_write = dec_fpw;
                        ctl_d.resume   = 1'b0;
                    end
                end
            end
            PH_ADDR: begin
                // ready is not looked at in the address clock
                ctl_d.ph = PH_DATA;
            end
            PH_DATA: begin
                if (rdy) begin
                    if (ctl_q.cnt == ctl_q.last_idx) begin
                        ctl_d.ph     = hold ? PH_HELD : PH_IDLE;
                        ctl_d.resume = 1'b0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                        if (ctl_q.yields && hold) begin
                            ctl_d.ph     = PH_HELD;
                            ctl_d.resume = 1'b1;
                        end else begin
                            ctl_d.ph = PH_ADDR;
                        end
                    end
                end
            end
            PH_HELD: begin
                if (!hold) begin
                    ctl_d.ph = ctl_q.resume ? PH_ADDR : PH_IDLE;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    plock_out_decode #(
        .CNT_W (CNT_W)
    ) u_out (
        .ph        (ctl_q.ph),
        .cnt       (ctl_q.cnt),
        .last_idx  (ctl_q.last_idx),
        .locked    (ctl_q.locked),
        .fp_write  (ctl_q.fp_write),
        .resume    (ctl_q.resume),
        .cyc_start (cyc_start),
        .lock_n    (lock_n),
        .lock_oe   (lock_oe),
        .last_n    (last_n),
        .hlda      (hlda)
    );

    assign cyc_num = ctl_q.cnt;

endmodule

// File: rtl/plock_xfer_ctrl_chk.sv
module plock_xfer_ctrl_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold,
    input logic             req_accept,
    input logic             req_err,
    input logic             cyc_start,
    input logic [CNT_W-1:0] cyc_num,
    input logic             lock_n,
    input logic             lock_oe,
    input logic             last_n,
    input logic             hlda
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (lock_n && last_n && !hlda && !cyc_start && lock_oe));

    assert_lock_opens_on_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> cyc_start);

    assert_overlap_first_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_n && !last_n) |-> (cyc_num == '0));

    assert_float_while_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!lock_oe && !cyc_start));

    assert_grant_follows_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(hold));

    assert_reject_no_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !cyc_start);

    assert_accept_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> (cyc_start && cyc_num == '0));
endmodule

bind plock_xfer_ctrl plock_xfer_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .req_accept (req_accept),
    .req_err    (req_err),
    .cyc_start  (cyc_start),
    .cyc_num    (cyc_num),
    .lock_n     (lock_n),
    .lock_oe    (lock_oe),
    .last_n     (last_n),
    .hlda       (hlda)
);

// File: tb/tb_plock_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_plock_xfer_ctrl;
    localparam int CLK_NS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [3:0] req_off = 4'd0;
    logic       rdy = 1'b0;
    logic       hold = 1'b0;
    logic       req_accept, req_err, cyc_start, lock_n, lock_oe, last_n, hlda;
    logic [1:0] cyc_num;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_NS/2.0) clk = ~clk;

    plock_xfer_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_off(req_off), .rdy(rdy), .hold(hold), .req_accept(req_accept),
        .req_err(req_err), .cyc_start(cyc_start), .cyc_num(cyc_num),
        .lock_n(lock_n), .lock_oe(lock_oe), .last_n(last_n), .hlda(hlda)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int beats_of(input int k);
        if (k == 2 || k == 5) return 4;
        if (k == 0) return 1;
        return 2;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R2 R3 R4 R5 R6 R10 R11: one transfer, cycle by cycle
    task automatic do_xfer(input int k, input int off, input int nwait, input bit hold_mid, input string req);
        int  n;
        bit  lk;
        bit  fw;
        n  = beats_of(k);
        lk = (k != 0);
        fw = (k == 4);
        @(negedge clk);
        req_kind = 3'(k); req_off = 4'(off); req_valid = 1'b1;
        #1;
        chk(req, "req_accept", req_accept, 1);
        chk(req, "req_err", req_err, 0);
        step();
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit lock_exp;
            bit last_exp;
            lock_exp = lk && (i != n - 1);
            last_exp = (i == n - 1) || (fw && i == 0);
            chk(req, "cyc_start(addr clk)", cyc_start, 1);
            chk(req, "cyc_num", cyc_num, i);
            chk(req, "lock_n(addr)", lock_n, !lock_exp);
            chk(req, "last_n(addr)", last_n, !last_exp);
            chk(req, "hlda in transfer", hlda, 0);
            if (i == 0 && hold_mid) hold = 1'b1;
            rdy = 1'b1; // R10: ignored in address clock
            step();
            for (int w = 0; w < nwait; w++) begin
                rdy = 1'b0;
                chk(req, "cyc_start(wait)", cyc_start, 0);
                chk(req, "lock_n(wait)", lock_n, !lock_exp);
                chk(req, "last_n(wait)", last_n, !last_exp);
                step();
            end
            rdy = 1'b1;
            chk(req, "cyc_start(data)", cyc_start, 0);
            chk(req, "lock_n(data)", lock_n, !lock_exp);
            chk(req, "last_n(data)", last_n, !last_exp);
            chk(req, "hlda in transfer(data)", hlda, 0);
            step();
            rdy = 1'b0;
        end
        if (hold_mid) begin
            chk(req, "hlda after final ready", hlda, 1);
            chk(req, "lock_oe held", lock_oe, 0);
            hold = 1'b0;
            step();
            chk(req, "hlda released", hlda, 0);
        end else begin
            chk(req, "hlda idle", hlda, 0);
        end
        chk(req, "lock_n idle", lock_n, 1);
        chk(req, "last_n idle", last_n, 1);
        chk(req, "cyc_start idle", cyc_start, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "lock_n", lock_n, 1);
        chk("R1", "last_n", last_n, 1);
        chk("R1", "hlda", hlda, 0);
        chk("R1", "cyc_start", cyc_start, 0);
        chk("R1", "lock_oe", lock_oe, 1);
        chk("R1", "cyc_num", cyc_num, 0);
        rst_n = 1'b1;
        // R10: ready while idle does nothing
        rdy = 1'b1;
        step(); step();
        chk("R10", "cyc_start idle rdy", cyc_start, 0);
        chk("R10", "last_n idle rdy", last_n, 1);
        rdy = 1'b0;
    endtask

    task automatic t_prefetch_hold();
        @(negedge clk);
        req_kind = 3'd5; req_off = 4'd0; req_valid = 1'b1;
        #1;
        chk("R7", "accept prefetch", req_accept, 1);
        step();
        req_valid = 1'b0;
        chk("R7", "lock_n cyc0", lock_n, 0);
        hold = 1'b1; rdy = 1'b1;
        step();
        chk("R7", "hlda during cycle", hlda, 0);
        step();
        chk("R7", "hlda at boundary", hlda, 1);
        chk("R7", "lock_oe floated", lock_oe, 0);
        chk("R7", "cyc_start held", cyc_start, 0);
        rdy = 1'b0;
        step(); step();
        chk("R7", "still held", hlda, 1);
        chk("R7", "no cycle held", cyc_start, 0);
        hold = 1'b0;
        step();
        chk("R7", "hlda dropped", hlda, 0);
        for (int i = 1; i < 4; i++) begin
            chk("R7", "resume cyc_start", cyc_start, 1);
            chk("R7", "resume cyc_num", cyc_num, i);
            chk("R7", "resume lock_oe", lock_oe, 1);
            chk("R7", "resume lock_n", lock_n, (i == 3) ? 1 : 0);
            chk("R7", "resume last_n", last_n, (i == 3) ? 0 : 1);
            rdy = 1'b1;
            step(); step();
            rdy = 1'b0;
        end
        chk("R7", "idle after prefetch", cyc_start, 0);
        chk("R7", "lock_n after prefetch", lock_n, 1);
    endtask

    task automatic t_idle_hold();
        @(negedge clk);
        hold = 1'b1;
        #1;
        chk("R8", "hlda not yet", hlda, 0);
        step();
        chk("R8", "hlda granted", hlda, 1);
        chk("R8", "lock_oe floated", lock_oe, 0);
        req_kind = 3'd1; req_off = 4'd0; req_valid = 1'b1;
        #1;
        chk("R8", "no accept while held", req_accept, 0);
        step();
        chk("R8", "no cycle while held", cyc_start, 0);
        req_valid = 1'b0; hold = 1'b0;
        step();
        chk("R8", "hlda released", hlda, 0);
        chk("R8", "no cycle after release", cyc_start, 0);
    endtask

    task automatic t_reject(input int k, input int off, input bit exp_err, input string req);
        @(negedge clk);
        req_kind = 3'(k); req_off = 4'(off); req_valid = 1'b1;
        #1;
        chk(req, $sformatf("req_err kind %0d off %0d", k, off), req_err, exp_err);
        chk(req, $sformatf("req_accept kind %0d off %0d", k, off), req_accept, !exp_err);
        step();
        req_valid = 1'b0;
        chk(req, "cyc_start after request", cyc_start, !exp_err);
        if (!exp_err) begin
            rdy = 1'b1;
            while (cyc_start || !last_n) step();
            rdy = 1'b0;
        end
    endtask

    initial begin
        t_reset();
        do_xfer(0, 3, 0, 1'b0, "R2");   // plain single, unlocked
        do_xfer(1, 8, 0, 1'b0, "R3");   // descriptor read
        do_xfer(2, 0, 2, 1'b0, "R4");   // line fill with waits
        do_xfer(3, 0, 1, 1'b0, "R4");   // fp long read
        do_xfer(4, 8, 0, 1'b0, "R5");   // fp long write, overlap
        do_xfer(4, 0, 3, 1'b0, "R5");
        do_xfer(2, 0, 0, 1'b1, "R6");   // hold mid fill
        do_xfer(1, 0, 1, 1'b1, "R6");   // hold mid descriptor read
        t_prefetch_hold();
        t_idle_hold();
        t_reject(1, 4, 1'b1, "R9");
        t_reject(3, 12, 1'b1, "R9");
        t_reject(2, 8, 1'b1, "R9");
        t_reject(5, 4, 1'b1, "R9");
        t_reject(7, 0, 1'b1, "R2");
        t_reject(6, 0, 1'b1, "R2");
        t_reject(4, 8, 1'b0, "R9");
        t_reject(0, 5, 1'b0, "R11");
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule